// File: doc/BRIEF.md
# CPU Clock Divider and Source Multiplexer

This block derives a CPU clock from one of two slow source clocks, a fast PLL clock and a crystal clock. Two 32-bit control words are written over a simple register bus. One word selects the divider source, the divide ratio and the final output source. The other holds a 9-bit half-ratio value N, which is used for even division. The divider offers fixed ratios of 1, 2 and 3, or an even ratio of 2×N. A final multiplexer either passes the divided clock or bypasses to the crystal, so the output can be parked on the crystal while the PLL settles.

The block runs on one fast system clock, `clk`. Both source clocks are synchronised into that domain and are treated as level signals. Each rising or falling edge of the selected source advances the divider counter. The output is a registered level. For this reason each source half-period must last at least two `clk` cycles. Glitch-free switching between sources is not part of this block.

Top module: `cpu_clock_divmux`

## Requirements
- R1: After reset both control words read as zero, and `cpu_clk` follows the crystal clock.
- R2: A write to offset 0x40 sets the main word and a write to offset 0x00 sets the divider word. Both words read back all 32 bits one cycle after the read request. At any other offset a write has no effect and a read returns zero.
- R3: Main word bit 7 is the final select. When it is 0, `cpu_clk` is the synchronised crystal level. When it is 1, `cpu_clk` is the divider output.
- R4: Main word bit 0 picks the divider source: 1 selects the PLL clock and 0 selects the crystal clock.
- R5: Main word bits [3:2] hold the ratio code. Codes 0, 1 and 2 give an output period of 1, 2 and 3 source periods.
- R6: Ratio code 3 gives an output period of 2×N source periods, where N is divider word bits [28:20].
- R7: With ratio code 3 and N equal to 0, the divider output is held low.
- R8: With the final select at 0, a change on the crystal input appears on `cpu_clk` at the third rising edge of `clk`.
- R9: The divider output changes only on a synchronised edge of the selected source. For a ratio R it is high for R of every 2R source edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the block window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pll_clk | input | 1 | Fast PLL source clock |
| xtal_clk | input | 1 | Crystal source clock |
| cpu_clk | output | 1 | Generated CPU clock |

## Verification
A corrupted divider counter or ratio decode changes the length of the very next output period. A period count at the ports shows it within one output cycle, and the cycle-exact model shows it at the first edge that lands in the wrong cycle. A wrong source or final select changes the output period at once, or leaves the output locked to the crystal. A wrong register decode appears at the next read-back.

// File: rtl/cpuclk_pkg.sv
`timescale 1ns/1ps
package cpuclk_pkg;
  // ratio code in the main control word
  typedef enum logic [1:0] {
    RATIO_ONE  = 2'd0,
    RATIO_TWO  = 2'd1,
    RATIO_THR  = 2'd2,
    RATIO_EVEN = 2'd3
  } ratio_code_e;
endpackage

// File: rtl/cpuclk_regs.sv
`timescale 1ns/1ps
module cpuclk_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] MAIN_OFS = 'h40,
  parameter logic [ADDR_W-1:0] AUX_OFS  = 'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] main_q,
  output logic [DATA_W-1:0] aux_q
);
  logic hit_main, hit_aux;
  assign hit_main = (bus_addr == MAIN_OFS);
  assign hit_aux  = (bus_addr == AUX_OFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q    <= '0;
      aux_q     <= '0;
      bus_rdata <= '0;
    end else if (bus_sel) begin
      if (bus_we) begin
        if (hit_main) main_q <= bus_wdata;
        if (hit_aux)  aux_q  <= bus_wdata;
      end else begin
        bus_rdata <= hit_main ? main_q : (hit_aux ? aux_q : '0);
      end
    end
  end
endmodule

// File: rtl/cpuclk_sync.sv
`timescale 1ns/1ps
module cpuclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic lvl,
  output logic edge_p
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign lvl    = chain[STAGES-1];
  assign edge_p = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/cpuclk_div.sv
`timescale 1ns/1ps
module cpuclk_div
  import cpuclk_pkg::*;
#(
  parameter int N_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           src_edge,
  input  ratio_code_e    code,
  input  logic [N_W-1:0] half_n,
  output logic           div_q
);
  localparam int R_W = N_W + 1;
  localparam int C_W = R_W + 1;

  logic [R_W-1:0] ratio;
  logic [C_W-1:0] last_cnt, cnt_q, cnt_nx;

  always_comb begin
    unique case (code)
      RATIO_ONE:  ratio = R_W'(1);
      RATIO_TWO:  ratio = R_W'(2);
      RATIO_THR:  ratio = R_W'(3);
      default:    ratio = {half_n, 1'b0};
    endcase
  end

  assign last_cnt = {ratio, 1'b0} - C_W'(1);
  assign cnt_nx   = (cnt_q >= last_cnt) ? '0 : cnt_q + C_W'(1);

  always_ff @(posedge clk) begin
    if (rst || ratio == '0) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (src_edge) begin
      cnt_q <= cnt_nx;
      div_q <= (cnt_nx >= C_W'(ratio));
    end
  end
endmodule

// File: rtl/cpu_clock_divmux.sv
`timescale 1ns/1ps
module cpu_clock_divmux
  import cpuclk_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int N_W       = 9,
  parameter int N_LSB     = 20,
  parameter int CODE_LSB  = 2,
  parameter int FINAL_BIT = 7,
  parameter int SRC_BIT   = 0,
  parameter int SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pll_clk,
  input  logic              xtal_clk,
  output logic              cpu_clk
);
  localparam int NSRC = 2;  // index 0 = crystal, 1 = PLL

  logic [DATA_W-1:0] main_q, aux_q;
  logic [NSRC-1:0]   src_raw, src_lvl, src_edg;
  logic              src_edge, div_q, xtal_lvl;

  cpuclk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .main_q(main_q), .aux_q(aux_q)
  );

  assign src_raw = {pll_clk, xtal_clk};

  for (genvar g = 0; g < NSRC; g++) begin : g_sync
    cpuclk_sync #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst(rst), .async_in(src_raw[g]),
      .lvl(src_lvl[g]), .edge_p(src_edg[g])
    );
  end

  assign xtal_lvl = src_lvl[0];
  assign src_edge = main_q[SRC_BIT] ? src_edg[1] : src_edg[0];

  cpuclk_div #(.N_W(N_W)) u_div (
    .clk(clk), .rst(rst), .src_edge(src_edge),
    .code(ratio_code_e'(main_q[CODE_LSB +: 2])),
    .half_n(aux_q[N_LSB +: N_W]),
    .div_q(div_q)
  );

  always_ff @(posedge clk) begin
    if (rst) cpu_clk <= 1'b0;
    else     cpu_clk <= main_q[FINAL_BIT] ? div_q : xtal_lvl;
  end
endmodule

// File: rtl/cpu_clock_divmux_chk.sv
`timescale 1ns/1ps
module cpu_clock_divmux_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int N_W       = 9,
  parameter int N_LSB     = 20,
  parameter int CODE_LSB  = 2,
  parameter int FINAL_BIT = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] main_q,
  input logic [DATA_W-1:0] aux_q,
  input logic              xtal_lvl,
  input logic              src_edge,
  input logic              div_q,
  input logic              cpu_clk
);
  logic n_zero_even;
  assign n_zero_even = (main_q[CODE_LSB +: 2] == 2'd3) && (aux_q[N_LSB +: N_W] == '0);

  assert_main_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr == ADDR_W'('h40)) |=> (bus_rdata == $past(main_q)));

  assert_bypass_xtal_R3: assert property (@(posedge clk) disable iff (rst)
    !main_q[FINAL_BIT] |=> (cpu_clk == $past(xtal_lvl)));

  assert_pass_divider_R3: assert property (@(posedge clk) disable iff (rst)
    main_q[FINAL_BIT] |=> (cpu_clk == $past(div_q)));

  assert_zero_n_low_R7: assert property (@(posedge clk) disable iff (rst)
    n_zero_even |=> !div_q);

  assert_edge_only_R9: assert property (@(posedge clk) disable iff (rst)
    (!src_edge && !n_zero_even) |=> $stable(div_q));
endmodule

bind cpu_clock_divmux cpu_clock_divmux_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_W(N_W), .N_LSB(N_LSB),
  .CODE_LSB(CODE_LSB), .FINAL_BIT(FINAL_BIT)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .main_q(main_q),
  .aux_q(aux_q), .xtal_lvl(xtal_lvl), .src_edge(src_edge),
  .div_q(div_q), .cpu_clk(cpu_clk)
);

// File: tb/test_cpu_clock_divmux.sv
`timescale 1ns/1ps
module test_cpu_clock_divmux;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pll_clk = 1'b0, xtal_clk = 1'b0;
  logic        cpu_clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // source generators (half-periods in clk cycles)
  int  p_half = 2, x_half = 5, pc = 0, xc = 0;
  bit  auto_src = 1;
  bit  pv = 0, xv = 0;

  // reference model state
  int  m_main = 0, m_aux = 0, m_rd = 0, m_cnt = 0;
  bit  m_dq = 0, m_cpu = 0;
  bit  p1 = 0, p2 = 0, p3 = 0, x1 = 0, x2 = 0, x3 = 0;

  cpu_clock_divmux i_cpu_clock_divmux (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pll_clk(pll_clk), .xtal_clk(xtal_clk), .cpu_clk(cpu_clk)
  );

  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clk cycle: drive at negedge, model the coming posedge, compare at next negedge
  task automatic step(input bit sel, input bit we, input logic [7:0] addr, input logic [31:0] wd);
    int r, code, n, nm, na;
    bit edg;
    if (auto_src) begin
      pc++; if (pc >= p_half) begin pc = 0; pv = !pv; end
      xc++; if (xc >= x_half) begin xc = 0; xv = !xv; end
    end
    pll_clk = pv; xtal_clk = xv;
    bus_sel = sel; bus_we = we; bus_addr = addr; bus_wdata = wd;
    if (!rst) begin
      code = (m_main >> 2) & 3;
      n    = (m_aux >> 20) & 511;
      r    = (code < 3) ? code + 1 : 2 * n;
      edg  = (m_main & 1) ? (p2 != p3) : (x2 != x3);
      m_cpu = ((m_main >> 7) & 1) ? m_dq : x2;
      if (r == 0) begin m_cnt = 0; m_dq = 0; end
      else if (edg) begin
        m_cnt = (m_cnt >= 2 * r - 1) ? 0 : m_cnt + 1;
        m_dq  = (m_cnt >= r);
      end
      p3 = p2; p2 = p1; p1 = pv;
      x3 = x2; x2 = x1; x1 = xv;
      nm = m_main; na = m_aux;
      if (sel && we) begin
        if (addr == 8'h40) nm = wd;
        if (addr == 8'h00) na = wd;
      end
      if (sel && !we) m_rd = (addr == 8'h40) ? m_main : ((addr == 8'h00) ? m_aux : 0);
      m_main = nm; m_aux = na;
    end
    @(posedge clk); @(negedge clk);
    if (!rst) chk(cpu_clk == m_cpu, "R9 cycle model cpu_clk", cpu_clk, m_cpu);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1, 1, a, d);
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
    step(1, 0, a, 0);
    chk(bus_rdata == exp, req, bus_rdata, exp);
    chk(bus_rdata == 32'(m_rd), {req, " model"}, bus_rdata, m_rd);
  endtask

  // measure the cycle count between two cpu_clk rising edges
  task automatic period_check(input int exp, input string req);
    int t, last;
    bit prev;
    idle(150);
    prev = cpu_clk; last = -1; t = 0;
    for (int i = 0; i < 6 * exp + 20; i++) begin
      step(0, 0, 8'h00, 0);
      t++;
      if (cpu_clk && !prev) begin
        if (last >= 0) break;
        last = t;
      end
      prev = cpu_clk;
    end
    chk((t - last) == exp, req, t - last, exp);
  endtask

  initial begin
    int hold_cnt;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(cpu_clk == 1'b0, "R1 cpu_clk at reset", cpu_clk, 0);
    rd_check(8'h40, 32'h0, "R1 main word reset");
    rd_check(8'h00, 32'h0, "R1 divider word reset");
    period_check(2 * x_half, "R1 follows crystal after reset");

    // R2 register access
    wr(8'h00, 32'hA5A5_5A5A);
    wr(8'h40, 32'hFFFF_FF7F);
    rd_check(8'h00, 32'hA5A5_5A5A, "R2 divider word readback");
    rd_check(8'h40, 32'hFFFF_FF7F, "R2 main word readback");
    wr(8'h20, 32'h1234_5678);
    rd_check(8'h20, 32'h0, "R2 unmapped read is zero");
    rd_check(8'h40, 32'hFFFF_FF7F, "R2 unmapped write ignored main");
    rd_check(8'h00, 32'hA5A5_5A5A, "R2 unmapped write ignored divider");

    // R4/R5 PLL source, fixed ratios
    wr(8'h00, 32'h0);
    wr(8'h40, 32'h81); period_check(2 * p_half * 1, "R5 ratio code 0 from PLL");
    wr(8'h40, 32'h85); period_check(2 * p_half * 2, "R5 ratio code 1 from PLL");
    wr(8'h40, 32'h89); period_check(2 * p_half * 3, "R5 ratio code 2 from PLL");

    // R6 even ratio
    wr(8'h00, 32'(2) << 20);
    wr(8'h40, 32'h8D); period_check(2 * p_half * 4, "R6 N=2 even ratio");
    wr(8'h00, (32'(5) << 20) | 32'h000F_FFFF);
    period_check(2 * p_half * 10, "R6 N=5 even ratio");
    wr(8'h00, 32'(511) << 20);
    period_check(2 * p_half * 1022, "R6 N=511 even ratio");

    // R7 N of zero holds output low
    wr(8'h00, 32'h0);
    idle(5);
    hold_cnt = 0;
    for (int i = 0; i < 60; i++) begin
      step(0, 0, 8'h00, 0);
      if (cpu_clk) hold_cnt++;
    end
    chk(hold_cnt == 0, "R7 N=0 output held low", hold_cnt, 0);

    // R4 crystal as divider source
    wr(8'h40, 32'h84); period_check(2 * x_half * 2, "R4 crystal source ratio 2");
    wr(8'h40, 32'h85); period_check(2 * p_half * 2, "R4 PLL source ratio 2");

    // R3 bypass ignores divider setting
    wr(8'h40, 32'h09); period_check(2 * x_half, "R3 final select 0 bypasses divider");

    // R8 latency on crystal path
    wr(8'h40, 32'h00);
    auto_src = 0; xv = 0;
    idle(10);
    xv = 1;
    hold_cnt = 0;
    for (int i = 1; i <= 6; i++) begin
      step(0, 0, 8'h00, 0);
      if (cpu_clk && hold_cnt == 0) hold_cnt = i;
    end
    chk(hold_cnt == 3, "R8 crystal to cpu_clk latency", hold_cnt, 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule